// File: doc/BRIEF.md
# E1 Channel Descriptor Exchange

This block is the register-side meeting point between software and the framing engine of one direction of an E1 line. Software hands the engine buffer descriptors, each of which names a 7-bit multiframe slot in the shared buffer. The engine claims them one at a time and fills (receive) or drains (transmit) that slot. When it finishes a slot it hands the descriptor back, and software collects it by reading the same descriptor address. Two four-entry queues carry the descriptors: one from software towards the engine, one back.

A single control/status word sets the enable bit and the framing options. On reads it reports the queue flags, the line alignment (receive only) and a sticky starvation flag. The engine sets this flag when it asks for a descriptor and none is queued; in receive this is an overflow, in transmit an underflow. Software clears it by writing a one to bit 12. A parameter selects the receive or transmit variant. The line framing itself is out of scope and appears as a take/done handshake on the ports.

Top module: `e1_bdq_chan`

## Requirements
- R1: After reset the status word reads 0x0000_0500 (bit 8 input queue empty, bit 10 output queue empty, all else zero), and a descriptor read returns 0.
- R2: Writing the control word latches bit 0 as the channel enable. The status word reports it in bit 0, and so does `cfg_en_o`.
- R3: Control bits 2:1 drive `cfg_mode_o`. In the transmit variant, bits 3, 4 and 5 drive `cfg_tick_remote_o`, `cfg_alarm_o` and `cfg_loopback_o`. In the receive variant those three outputs stay 0.
- R4: Status bit 1 follows `line_aligned_i` in the receive variant and reads 0 in the transmit variant.
- R5: A write to the descriptor address (`reg_addr_i`=1) queues bits 6:0 of the write data. The queue holds 4 entries, a write to a full queue is dropped, and status bits 8 and 9 report input queue empty and full.
- R6: While enabled and idle, an `eng_take_i` pulse moves the oldest queued descriptor to the engine (`eng_busy_o`, `eng_mf_o`). An `eng_done_i` pulse returns it to the output queue. Status bits 10 and 11 report output queue empty and full.
- R7: A read of the descriptor address returns the oldest completed descriptor with bit 15 set and the slot in bits 6:0, and removes it. In receive, bits 14 and 13 carry `eng_crc_i[1]` and `eng_crc_i[0]` sampled at completion. In transmit they read 0.
- R8: A descriptor read with the output queue empty returns 0 and changes no state.
- R9: A take while enabled, idle and with the input queue empty sets sticky status bit 12. The bit stays set through control writes that leave bit 12 at 0.
- R10: A control write with bit 12 set clears the sticky flag. If a starving take happens in the same cycle, the flag ends up set.
- R11: A take is ignored while the channel is disabled or the engine is busy. A done is ignored while the output queue is full, and the engine keeps its descriptor until a later done succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 1 | 0 = control/status word, 1 = descriptor word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops on a descriptor read) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| line_aligned_i | input | 1 | Alignment indication from the receive framer |
| eng_take_i | input | 1 | Engine requests its next descriptor |
| eng_done_i | input | 1 | Engine finished the active descriptor |
| eng_crc_i | input | 2 | CRC pass status of the two sub-multiframe halves |
| eng_busy_o | output | 1 | Engine holds an active descriptor |
| eng_mf_o | output | 7 | Multiframe slot of the active descriptor |
| cfg_en_o | output | 1 | Channel enable |
| cfg_mode_o | output | 2 | Framing mode |
| cfg_tick_remote_o | output | 1 | Transmit timing from the remote tick |
| cfg_alarm_o | output | 1 | Transmit alarm |
| cfg_loopback_o | output | 1 | Transmit loopback |

## Verification
The bench fills the input queue past its depth. A design that overwrites the oldest entry or wraps its pointer early would return a slot that was never accepted, or lose the first one. It fills the output queue and then completes once more, which catches a design that drops the engine's descriptor instead of holding it. It reads an empty output queue, where a wrong design would return a stale valid word or move its read pointer. It also issues a starvation take in the same cycle as a flag clear, where a wrong priority would leave the flag cleared. Receive and transmit instances run side by side on the same stimulus, so CRC bits leaking into transmit completions show up at once.

// File: rtl/e1_bdq_pkg.sv
`timescale 1ns/1ps
package e1_bdq_pkg;

  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} e1_dir_e;

  localparam int  MF_W     = 7;
  localparam logic ADDR_CSR = 1'b0;
  localparam logic ADDR_BD  = 1'b1;

  // status / descriptor bit positions (decoded by software)
  localparam int ST_EN     = 0;
  localparam int ST_ALIGN  = 1;
  localparam int ST_IEMPTY = 8;
  localparam int ST_IFULL  = 9;
  localparam int ST_OEMPTY = 10;
  localparam int ST_OFULL  = 11;
  localparam int ST_ERR    = 12;
  localparam int BD_VALID  = 15;
  localparam int BD_CRC_LO = 13;

  typedef struct packed {
    logic [1:0]      crc;
    logic [MF_W-1:0] mf;
  } done_bd_t;

  function automatic logic [31:0] pack_bd(input logic valid, input done_bd_t d);
    logic [31:0] w;
    w = '0;
    if (valid) begin
      w[BD_VALID]               = 1'b1;
      w[BD_CRC_LO+1:BD_CRC_LO]  = d.crc;
      w[MF_W-1:0]               = d.mf;
    end
    return w;
  endfunction

  function automatic logic [31:0] pack_status(input logic en, input logic align,
                                              input logic ie, input logic ifl,
                                              input logic oe, input logic ofl,
                                              input logic err);
    logic [31:0] w;
    w            = '0;
    w[ST_EN]     = en;
    w[ST_ALIGN]  = align;
    w[ST_IEMPTY] = ie;
    w[ST_IFULL]  = ifl;
    w[ST_OEMPTY] = oe;
    w[ST_OFULL]  = ofl;
    w[ST_ERR]    = err;
    return w;
  endfunction

endpackage

// File: rtl/e1_bdq_fifo.sv
`timescale 1ns/1ps
module e1_bdq_fifo #(
  parameter int WIDTH = 7,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[i] <= '0;
      else if (push_ok && wp == AW'(i))        mem[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= ptr_next(wp);
      if (pop_ok)  rp <= ptr_next(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(cnt) && $stable(wp)));
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> ($stable(cnt) && $stable(rp)));

endmodule

// File: rtl/e1_bdq_csr.sv
`timescale 1ns/1ps
module e1_bdq_csr
  import e1_bdq_pkg::*;
#(
  parameter e1_dir_e DIR = DIR_RX
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        starve_i,
  output logic        en_o,
  output logic [1:0]  mode_o,
  output logic        tick_remote_o,
  output logic        alarm_o,
  output logic        loopback_o,
  output logic        err_o
);
  logic [5:0] ctrl_q;
  logic       err_q;
  logic       err_clr;

  assign err_clr = wr_i && wdata_i[ST_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_i)          ctrl_q <= wdata_i[5:0];
      if (starve_i)      err_q  <= 1'b1;   // a new event beats a clear
      else if (err_clr)  err_q  <= 1'b0;
    end
  end

  assign en_o   = ctrl_q[0];
  assign mode_o = ctrl_q[2:1];
  assign err_o  = err_q;

  if (DIR == DIR_TX) begin : g_tx_opts
    assign tick_remote_o = ctrl_q[3];
    assign alarm_o       = ctrl_q[4];
    assign loopback_o    = ctrl_q[5];
  end else begin : g_rx_opts
    assign tick_remote_o = 1'b0;
    assign alarm_o       = 1'b0;
    assign loopback_o    = 1'b0;
  end

  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    starve_i |=> err_o);
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !err_clr) |=> err_o);
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !starve_i) |=> !err_o);

endmodule

// File: rtl/e1_bdq_engine.sv
`timescale 1ns/1ps
module e1_bdq_engine
  import e1_bdq_pkg::*;
#(
  parameter e1_dir_e DIR = DIR_RX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            take_i,
  input  logic            done_i,
  input  logic [1:0]      crc_i,
  input  logic            in_empty_i,
  input  logic [MF_W-1:0] in_mf_i,
  output logic            in_pop_o,
  input  logic            out_full_i,
  output logic            out_push_o,
  output done_bd_t        out_bd_o,
  output logic            starve_o,
  output logic            busy_o,
  output logic [MF_W-1:0] mf_o
);
  logic            busy_q;
  logic [MF_W-1:0] mf_q;
  logic            take_ok, done_ok;

  assign take_ok    = take_i && en_i && !busy_q;
  assign in_pop_o   = take_ok && !in_empty_i;
  assign starve_o   = take_ok && in_empty_i;
  assign done_ok    = done_i && busy_q && !out_full_i;
  assign out_push_o = done_ok;
  assign out_bd_o.mf = mf_q;

  if (DIR == DIR_RX) begin : g_rx_crc
    assign out_bd_o.crc = crc_i;
  end else begin : g_tx_crc
    assign out_bd_o.crc = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mf_q   <= '0;
    end else if (in_pop_o) begin
      busy_q <= 1'b1;
      mf_q   <= in_mf_i;
    end else if (done_ok) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign mf_o   = mf_q;

  assert_take_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !en_i && !done_i) |=> ($stable(busy_q) && $stable(mf_q)));
  assert_done_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && busy_q && out_full_i) |=> (busy_q && $stable(mf_q)));
  assert_take_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop_o |=> (busy_q && mf_q == $past(in_mf_i)));

endmodule

// File: rtl/e1_bdq_chan.sv
`timescale 1ns/1ps
module e1_bdq_chan
  import e1_bdq_pkg::*;
#(
  parameter e1_dir_e DIR    = DIR_RX,
  parameter int      QDEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        line_aligned_i,
  input  logic        eng_take_i,
  input  logic        eng_done_i,
  input  logic [1:0]  eng_crc_i,
  output logic        eng_busy_o,
  output logic [6:0]  eng_mf_o,
  output logic        cfg_en_o,
  output logic [1:0]  cfg_mode_o,
  output logic        cfg_tick_remote_o,
  output logic        cfg_alarm_o,
  output logic        cfg_loopback_o
);
  localparam int OUT_W = $bits(done_bd_t);

  logic            csr_wr, bd_wr, bd_rd;
  logic            in_empty, in_full, in_pop;
  logic [MF_W-1:0] in_mf;
  logic            out_empty, out_full, out_push;
  done_bd_t        out_din, out_head;
  logic            starve, err, align;

  assign csr_wr = reg_wr_i && (reg_addr_i == ADDR_CSR);
  assign bd_wr  = reg_wr_i && (reg_addr_i == ADDR_BD);
  assign bd_rd  = reg_rd_i && (reg_addr_i == ADDR_BD);
  assign align  = (DIR == DIR_RX) ? line_aligned_i : 1'b0;

  e1_bdq_fifo #(.WIDTH(MF_W), .DEPTH(QDEPTH)) u_in_q (
    .clk(clk), .rst_n(rst_n),
    .push(bd_wr), .din(reg_wdata_i[MF_W-1:0]),
    .pop(in_pop), .dout(in_mf),
    .empty(in_empty), .full(in_full)
  );

  e1_bdq_fifo #(.WIDTH(OUT_W), .DEPTH(QDEPTH)) u_out_q (
    .clk(clk), .rst_n(rst_n),
    .push(out_push), .din(out_din),
    .pop(bd_rd), .dout(out_head),
    .empty(out_empty), .full(out_full)
  );

  e1_bdq_csr #(.DIR(DIR)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_i(csr_wr), .wdata_i(reg_wdata_i), .starve_i(starve),
    .en_o(cfg_en_o), .mode_o(cfg_mode_o),
    .tick_remote_o(cfg_tick_remote_o), .alarm_o(cfg_alarm_o),
    .loopback_o(cfg_loopback_o), .err_o(err)
  );

  e1_bdq_engine #(.DIR(DIR)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .en_i(cfg_en_o), .take_i(eng_take_i), .done_i(eng_done_i), .crc_i(eng_crc_i),
    .in_empty_i(in_empty), .in_mf_i(in_mf), .in_pop_o(in_pop),
    .out_full_i(out_full), .out_push_o(out_push), .out_bd_o(out_din),
    .starve_o(starve), .busy_o(eng_busy_o), .mf_o(eng_mf_o)
  );

  always_comb begin
    if (reg_addr_i == ADDR_BD)
      reg_rdata_o = pack_bd(!out_empty, out_head);
    else
      reg_rdata_o = pack_status(cfg_en_o, align, in_empty, in_full,
                                out_empty, out_full, err);
  end

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_rd && out_empty) |-> (reg_rdata_o == 32'h0));
  assert_valid_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_rd && !out_empty) |-> reg_rdata_o[BD_VALID]);
  assert_in_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_take_i && cfg_en_o && !eng_busy_o && in_empty) |=> !eng_busy_o);

endmodule

// File: tb/e1_bdq_chan_tb.sv
`timescale 1ns/1ps
module e1_bdq_chan_tb_top;
  import e1_bdq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        aligned = 1'b0, take = 1'b0, done = 1'b0;
  logic [1:0]  crc = 2'b00;
  logic [31:0] rd_rx, rd_tx;
  logic        busy_rx, busy_tx, en_rx, en_tx;
  logic [6:0]  mf_rx, mf_tx;
  logic [1:0]  mode_rx, mode_tx;
  logic        tk_rx, al_rx, lb_rx, tk_tx, al_tx, lb_tx;

  always #4 clk = ~clk;   // 125 MHz

  e1_bdq_chan #(.DIR(DIR_RX)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(rd_rx),
    .line_aligned_i(aligned), .eng_take_i(take), .eng_done_i(done),
    .eng_crc_i(crc), .eng_busy_o(busy_rx), .eng_mf_o(mf_rx),
    .cfg_en_o(en_rx), .cfg_mode_o(mode_rx), .cfg_tick_remote_o(tk_rx),
    .cfg_alarm_o(al_rx), .cfg_loopback_o(lb_rx));

  e1_bdq_chan #(.DIR(DIR_TX)) dut_tx_i (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(rd_tx),
    .line_aligned_i(aligned), .eng_take_i(take), .eng_done_i(done),
    .eng_crc_i(crc), .eng_busy_o(busy_tx), .eng_mf_o(mf_tx),
    .cfg_en_o(en_tx), .cfg_mode_o(mode_tx), .cfg_tick_remote_o(tk_tx),
    .cfg_alarm_o(al_tx), .cfg_loopback_o(lb_tx));

  int n_chk = 0, n_fail = 0;

  // reference model
  bit          m_en = 0, m_err = 0, m_busy = 0;
  int          m_act = 0;
  int          in_q[$];
  int          sb_rx[$], sb_tx[$];   // scoreboard of expected completed words

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_status(input bit rx);
    int w = 0;
    w |= int'(m_en);
    if (rx && aligned) w |= 2;
    if (in_q.size() == 0) w |= 32'h100;
    if (in_q.size() == 4) w |= 32'h200;
    if (sb_rx.size() == 0) w |= 32'h400;
    if (sb_rx.size() == 4) w |= 32'h800;
    if (m_err) w |= 32'h1000;
    return w;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic csr_write(input int d);
    reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0;
    m_en = d[0];
    if (d[12]) m_err = 0;
  endtask

  task automatic bd_write(input int d);
    reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0;
    if (in_q.size() < 4) in_q.push_back(d & 32'h7f);
  endtask

  task automatic eng_take();
    take = 1'b1; step(); take = 1'b0;
    if (m_en && !m_busy) begin
      if (in_q.size() > 0) begin m_busy = 1; m_act = in_q.pop_front(); end
      else m_err = 1;
    end
  endtask

  // driver: completion pushes expected words into the scoreboard
  task automatic eng_done(input logic [1:0] c);
    crc = c; done = 1'b1; step(); done = 1'b0; crc = 2'b00;
    if (m_busy && sb_rx.size() < 4) begin
      sb_rx.push_back(32'h8000 | (int'(c) << 13) | m_act);
      sb_tx.push_back(32'h8000 | m_act);
      m_busy = 0;
    end
  endtask

  // monitor: descriptor read pops and compares against the scoreboard
  task automatic bd_read(input string req);
    int er, et;
    reg_addr = 1'b1; reg_rd = 1'b1; #1;
    er = (sb_rx.size() > 0) ? sb_rx.pop_front() : 0;
    et = (sb_tx.size() > 0) ? sb_tx.pop_front() : 0;
    chk({req, " rx desc"}, rd_rx, er);
    chk({req, " tx desc"}, rd_tx, et);
    step();
    reg_rd = 1'b0;
  endtask

  task automatic status_chk(input string req);
    reg_addr = 1'b0; #1;
    chk({req, " rx status"}, rd_rx, exp_status(1));
    chk({req, " tx status"}, rd_tx, exp_status(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    status_chk("R1");
    chk("R1 rx status value", rd_rx, 32'h500);
    bd_read("R1");

    // R2 / R3 enable and options
    csr_write(32'h3f);
    status_chk("R2");
    chk("R2 cfg_en", {en_rx, en_tx}, 2'b11);
    chk("R3 rx mode", mode_rx, 2'd3);
    chk("R3 tx mode", mode_tx, 2'd3);
    chk("R3 rx options zero", {tk_rx, al_rx, lb_rx}, 3'b000);
    chk("R3 tx options", {tk_tx, al_tx, lb_tx}, 3'b111);
    csr_write(32'h0b);
    chk("R3 mode 1 tx options", {mode_tx, tk_tx, al_tx, lb_tx}, 5'b01100);

    // R4 alignment
    aligned = 1'b1; #1;
    status_chk("R4");
    aligned = 1'b0; #1;
    status_chk("R4 cleared");

    // R5 fill past depth, upper write bits ignored
    bd_write(32'hff85); bd_write(6); bd_write(7); bd_write(8);
    status_chk("R5 full");
    bd_write(9);
    status_chk("R5 drop");

    // R6 / R11 take, take while busy
    eng_take();
    chk("R6 busy", {busy_rx, busy_tx}, 2'b11);
    chk("R6 first slot", mf_rx, 7'd5);
    eng_take();
    chk("R11 take while busy", mf_rx, 7'd5);
    status_chk("R11 take while busy");
    eng_done(2'b10);
    chk("R6 idle after done", busy_rx, 1'b0);
    status_chk("R6 out nonempty");
    bd_read("R7");
    bd_read("R8 empty read");
    status_chk("R8 no side effect");

    // R6 / R11 fill output queue, blocked completion
    bd_write(10);
    eng_take(); eng_done(2'b11);
    eng_take(); eng_done(2'b00);
    eng_take(); eng_done(2'b01);
    eng_take(); eng_done(2'b11);
    status_chk("R6 out full");
    bd_write(11);
    eng_take();
    eng_done(2'b11);
    chk("R11 done blocked busy", {busy_rx, busy_tx}, 2'b11);
    chk("R11 done blocked slot", mf_rx, 7'd11);
    status_chk("R11 done blocked");
    for (int i = 0; i < 4; i++) bd_read("R7 order");
    eng_done(2'b01);
    bd_read("R7 late completion");

    // R11 take while disabled
    csr_write(32'h0);
    bd_write(12);
    eng_take();
    chk("R11 disabled take", busy_rx, 1'b0);
    status_chk("R11 disabled take");

    // R9 starvation
    csr_write(32'h1);
    eng_take(); eng_done(2'b11);
    bd_read("R7 after enable");
    eng_take();
    status_chk("R9 starve sets");
    csr_write(32'h3);
    status_chk("R9 sticky");

    // R10 clear, and set winning over clear
    csr_write(32'h1001);
    status_chk("R10 clear");
    reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = 32'h1001; take = 1'b1;
    step();
    reg_wr = 1'b0; take = 1'b0;
    m_err = 1;
    status_chk("R10 set wins");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule